// File: doc/BRIEF.md
# Transmit Cell-Bus Capture

This block receives ATM cells from an ATM-layer device over a transmit cell bus and turns them into a word stream for a downstream cell FIFO. The bus is 8 or 16 bits wide and is chosen at run time. Each cell starts with a start-of-cell strobe that comes in the same clock as the first octet or word. The block counts the accepted words against a cell length, which is also set at run time. When the count completes, it signals a commit. After that it ignores the bus until the next start-of-cell.

If a start-of-cell arrives before the current cell is complete, the partial cell is a runt. The block tells the FIFO to roll back the space the runt had taken, and it sets a sticky alignment-change interrupt. The strobe that ends the runt is taken as word 0 of a new cell. A configuration byte selects the bus width and the cell length, and holds several fields that other blocks use. The interrupt flag is cleared by writing 1 to it.

Top module: `utx_cell_capture`

## Requirements
- R1: The configuration byte resets to 0x00. A write stores bits 5:0: bit 0 is wide mode, bits 2:1 are the FIFO depth, bit 3 selects short cells, bit 4 is multi-PHY enable and bit 5 is handshake mode. Bits 7:6 always read 0. The written value can be read back on the clock after the write.
- R2: With bit 0 clear, each output word is {8'h00, tx_data[7:0]}. With bit 0 set, each output word is tx_data[15:0].
- R3: The cell length in accepted words depends on the mode. In 8-bit mode it is 52 with bit 3 set and 53 with bit 3 clear. In 16-bit mode it is 26 with bit 3 set and 27 with bit 3 clear. `cell_commit` pulses in the same cycle as the `wr_valid` of the last word.
- R4: A cycle with `tx_en` and `tx_soc` both high always starts a cell. The word in that cycle is word 0. Each accepted word appears on `wr_valid`/`wr_data` one clock after it is sampled.
- R5: A cycle with `tx_en` low is not sampled, even if `tx_soc` is high. It does not advance the word count.
- R6: After a cell completes, words that come without `tx_soc` are ignored and produce no `wr_valid`. This lasts until the next start-of-cell.
- R7: A start-of-cell that comes while a cell is incomplete pulses `cell_rollback` one clock later, and that partial cell is never committed. The strobe word is written as word 0 of the new cell.
- R8: `align_irq` is set by each runt and stays set until `irq_wr` comes with `irq_wdata` high. If a runt and a clear come in the same cycle, the flag stays set.
- R9: `cell_commit` and `cell_rollback` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read-back |
| irq_wr | input | 1 | Interrupt flag write strobe |
| irq_wdata | input | 1 | Writing 1 clears the flag |
| align_irq | output | 1 | Sticky alignment-change flag |
| tx_soc | input | 1 | Start-of-cell strobe |
| tx_en | input | 1 | Bus data valid/enable |
| tx_data | input | 16 | Transmit bus data |
| wr_valid | output | 1 | Word write to the cell FIFO |
| wr_data | output | 16 | Word to the cell FIFO |
| cell_commit | output | 1 | Complete cell, commit FIFO space |
| cell_rollback | output | 1 | Runt dropped, release FIFO space |

## Verification
The in-cell counter checks assume that the configuration byte is not rewritten while a cell is only partly received. If it changes mid-cell, the length the counter compares against moves beneath it. The stimulus therefore completes any open cell with enabled, non-strobe words before each configuration write. The random phase then mixes rare start-of-cell strobes, enable gaps and random data on both halves of the bus. This produces full cells, runts at any offset, strobes while idle and ignored words after a cell ends. A directed runt is placed on the last octet position, and a runt is placed in the same cycle as an interrupt clear.

// File: rtl/utx_pkg.sv
package utx_pkg;

  typedef struct packed {
    logic [1:0] rsvd;
    logic       hs_mode;
    logic       mphy_en;
    logic       short_cell;
    logic [1:0] fifo_depth;
    logic       wide;
  } utx_cfg_t;

  localparam logic [7:0] CFG_WMASK = 8'h3F;

  // Cell length in bus words for the selected width and cell size.
  function automatic int unsigned cell_words(input logic wide, input logic short_cell,
                                             input int unsigned short_oct,
                                             input int unsigned long_oct);
    int unsigned oct;
    oct = short_cell ? short_oct : long_oct;
    return wide ? (oct + 1) / 2 : oct;
  endfunction

  // Narrow mode zero-fills the upper half of the word.
  function automatic logic [15:0] bus_word(input logic wide, input logic [15:0] d);
    return wide ? d : {8'h00, d[7:0]};
  endfunction

endpackage

// File: rtl/utx_cfg_reg.sv
module utx_cfg_reg
  import utx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_wdata,
  input  logic       irq_wr,
  input  logic       irq_wdata,
  input  logic       runt_evt,
  output utx_cfg_t   cfg,
  output logic       irq_flag
);

  logic irq_clr;
  assign irq_clr = irq_wr && irq_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg      <= '0;
      irq_flag <= 1'b0;
    end else begin
      if (cfg_wr) cfg <= utx_cfg_t'(cfg_wdata & CFG_WMASK);
      if (runt_evt)     irq_flag <= 1'b1;
      else if (irq_clr) irq_flag <= 1'b0;
    end
  end

  // R1: reserved bits never become set
  a_r1_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n) cfg.rsvd == 2'b00);
  // R8: flag holds unless cleared
  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag);
  // R8: a runt always leaves the flag set
  a_r8_irq_set: assert property (@(posedge clk) disable iff (!rst_n) runt_evt |=> irq_flag);

endmodule

// File: rtl/utx_cell_ctr.sv
module utx_cell_ctr
  import utx_pkg::*;
#(
  parameter int unsigned SHORT_OCT = 52,
  parameter int unsigned LONG_OCT  = 53,
  localparam int unsigned CNT_W    = $clog2(LONG_OCT + 1)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wide,
  input  logic             short_cell,
  input  logic             soc_take,
  input  logic             data_take,
  output logic             accept,
  output logic             runt_evt,
  output logic             cell_done,
  output logic             active,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] len;
  logic             in_cell_data;

  assign len          = CNT_W'(cell_words(wide, short_cell, SHORT_OCT, LONG_OCT));
  assign in_cell_data = data_take && active;
  assign runt_evt     = soc_take && active;
  assign accept       = soc_take || in_cell_data;
  assign cell_done    = in_cell_data && (cnt == len - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (soc_take) begin
      active <= 1'b1;
      cnt    <= CNT_W'(1);
    end else if (in_cell_data) begin
      if (cell_done) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R3: open cell count stays inside the configured length
  a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt != 0 && cnt < len));
  // R3: a completed cell closes the counter
  a_r3_done_closes: assert property (@(posedge clk) disable iff (!rst_n)
    cell_done |=> !active);
  // R7: a runt always reopens a cell at word 1
  a_r7_runt_restart: assert property (@(posedge clk) disable iff (!rst_n)
    runt_evt |=> (active && cnt == CNT_W'(1)));

endmodule

// File: rtl/utx_out_stage.sv
module utx_out_stage
  import utx_pkg::*;
#(
  parameter int unsigned DATA_W = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide,
  input  logic              accept,
  input  logic              cell_done,
  input  logic              runt_evt,
  input  logic [DATA_W-1:0] bus_data,
  output logic              wr_valid,
  output logic [DATA_W-1:0] wr_data,
  output logic              cell_commit,
  output logic              cell_rollback
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid      <= 1'b0;
      wr_data       <= '0;
      cell_commit   <= 1'b0;
      cell_rollback <= 1'b0;
    end else begin
      wr_valid      <= accept;
      cell_commit   <= cell_done;
      cell_rollback <= runt_evt;
      if (accept) wr_data <= bus_word(wide, bus_data);
    end
  end

  // R9: commit and rollback are exclusive
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cell_commit && cell_rollback));
  // R3: commit rides on the last word write
  a_r3_commit_with_word: assert property (@(posedge clk) disable iff (!rst_n)
    cell_commit |-> wr_valid);

endmodule

// File: rtl/utx_cell_capture.sv
module utx_cell_capture
  import utx_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned SHORT_OCT = 52,
  parameter int unsigned LONG_OCT  = 53,
  localparam int unsigned CNT_W    = $clog2(LONG_OCT + 1)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              irq_wr,
  input  logic              irq_wdata,
  output logic              align_irq,
  input  logic              tx_soc,
  input  logic              tx_en,
  input  logic [DATA_W-1:0] tx_data,
  output logic              wr_valid,
  output logic [DATA_W-1:0] wr_data,
  output logic              cell_commit,
  output logic              cell_rollback
);

  utx_cfg_t         cfg;
  logic             soc_take, data_take;
  logic             accept, runt_evt, cell_done, active;
  logic [CNT_W-1:0] cnt;

  assign soc_take  = tx_en && tx_soc;
  assign data_take = tx_en && !tx_soc;
  assign cfg_rdata = cfg;

  utx_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .irq_wr(irq_wr), .irq_wdata(irq_wdata), .runt_evt(runt_evt),
    .cfg(cfg), .irq_flag(align_irq)
  );

  utx_cell_ctr #(.SHORT_OCT(SHORT_OCT), .LONG_OCT(LONG_OCT)) u_ctr (
    .clk(clk), .rst_n(rst_n), .wide(cfg.wide), .short_cell(cfg.short_cell),
    .soc_take(soc_take), .data_take(data_take), .accept(accept),
    .runt_evt(runt_evt), .cell_done(cell_done), .active(active), .cnt(cnt)
  );

  utx_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .wide(cfg.wide), .accept(accept),
    .cell_done(cell_done), .runt_evt(runt_evt), .bus_data(tx_data),
    .wr_valid(wr_valid), .wr_data(wr_data), .cell_commit(cell_commit),
    .cell_rollback(cell_rollback)
  );

  // R4: an enabled strobe is always written one clock later
  a_r4_soc_written: assert property (@(posedge clk) disable iff (!rst_n)
    soc_take |=> wr_valid);
  // R5: a disabled cycle writes nothing
  a_r5_idle_en: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !wr_valid);
  // R6: data outside a cell is dropped
  a_r6_ignore_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (data_take && !active) |=> !wr_valid);

endmodule

// File: tb/test_utx_cell_capture.sv
module test_utx_cell_capture;
  import utx_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, irq_wr = 1'b0, irq_wdata = 1'b0;
  logic [7:0]  cfg_wdata = '0, cfg_rdata;
  logic        tx_soc = 1'b0, tx_en = 1'b0;
  logic [15:0] tx_data = '0, wr_data;
  logic        align_irq, wr_valid, cell_commit, cell_rollback;

  int checks = 0, errors = 0;
  int commits = 0, rollbacks = 0;

  // bench model
  logic [7:0] m_cfg = '0;
  bit m_active = 0, m_irq = 0;
  int m_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  utx_cell_capture i_utx_cell_capture (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq_wr(irq_wr), .irq_wdata(irq_wdata),
    .align_irq(align_irq), .tx_soc(tx_soc), .tx_en(tx_en), .tx_data(tx_data),
    .wr_valid(wr_valid), .wr_data(wr_data), .cell_commit(cell_commit),
    .cell_rollback(cell_rollback)
  );

  function automatic int exp_len(logic [7:0] c);
    if (c[0]) return c[3] ? 26 : 27;
    return c[3] ? 52 : 53;
  endfunction

  function automatic logic [15:0] exp_word(logic [7:0] c, logic [15:0] d);
    return c[0] ? d : (d & 16'h00FF);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One clock: drive at negedge, compare registered outputs at next negedge.
  task automatic step(bit soc, bit en, logic [15:0] d, bit clr = 0);
    bit e_v = 0, e_c = 0, e_r = 0;
    logic [15:0] e_d = '0;
    tx_soc = soc; tx_en = en; tx_data = d;
    irq_wr = clr; irq_wdata = clr;
    @(negedge clk);
    tx_en = 0; tx_soc = 0; irq_wr = 0; irq_wdata = 0;
    if (clr) m_irq = 0;
    if (en && soc) begin
      if (m_active) begin e_r = 1; m_irq = 1; end
      e_v = 1; e_d = exp_word(m_cfg, d); m_cnt = 1; m_active = 1;
    end else if (en && m_active) begin
      e_v = 1; e_d = exp_word(m_cfg, d); m_cnt++;
      if (m_cnt == exp_len(m_cfg)) begin e_c = 1; m_active = 0; m_cnt = 0; end
    end
    chk(en ? (soc ? "R4" : "R6") : "R5", "wr_valid", wr_valid, e_v);
    if (e_v) chk("R2", "wr_data", wr_data, e_d);
    chk("R3", "cell_commit", cell_commit, e_c);
    chk("R7", "cell_rollback", cell_rollback, e_r);
    chk("R8", "align_irq", align_irq, m_irq);
    if (cell_commit) commits++;
    if (cell_rollback) rollbacks++;
  endtask

  task automatic finish_cell();
    while (m_active) step(0, 1, 16'($urandom));
  endtask

  task automatic write_cfg(logic [7:0] v);
    finish_cell();
    cfg_wr = 1; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 0;
    m_cfg = v & 8'h3F;
    chk("R1", "cfg_rdata", cfg_rdata, m_cfg);
  endtask

  task automatic send_cell(int n, bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps) step(1'b0, 1'b0, 16'($urandom));
      step(i == 0, 1, 16'($urandom));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk("R1", "reset cfg_rdata", cfg_rdata, 0);
    chk("R8", "reset align_irq", align_irq, 0);
    chk("R4", "reset wr_valid", wr_valid, 0);

    // R1: reserved bits masked
    write_cfg(8'hFF);
    write_cfg(8'h00);

    // R3: 8-bit, 53 octets, with enable gaps (R5), strobe while disabled
    commits = 0;
    step(1, 0, 16'hABCD);
    send_cell(53, 1);
    chk("R3", "commit count 53", commits, 1);
    // R6: ignored words after the cell
    for (int i = 0; i < 5; i++) step(0, 1, 16'h1234);
    // R3: 52 octets, 8-bit
    write_cfg(8'h08);
    commits = 0; send_cell(52, 0);
    chk("R3", "commit count 52", commits, 1);
    // R2/R3: 16-bit, 26 and 27 words
    write_cfg(8'h09);
    commits = 0; send_cell(26, 0);
    chk("R3", "commit count 26", commits, 1);
    write_cfg(8'h01);
    commits = 0; send_cell(27, 0);
    chk("R3", "commit count 27", commits, 1);

    // R7: runt on the last-octet position in 8-bit 53 mode
    write_cfg(8'h00);
    rollbacks = 0; commits = 0;
    send_cell(52, 0);
    step(1, 1, 16'h00AA);
    chk("R7", "runt rollback", rollbacks, 1);
    chk("R7", "runt no commit", commits, 0);
    for (int i = 1; i < 53; i++) step(0, 1, 16'($urandom));
    chk("R7", "new cell commits", commits, 1);

    // R8: clear, then runt with simultaneous clear keeps flag
    step(0, 0, 0, 1);
    chk("R8", "irq cleared", align_irq, 0);
    send_cell(3, 0);
    step(1, 1, 16'h0055, 1);
    chk("R8", "set wins over clear", align_irq, 1);
    step(0, 0, 0, 1);

    // random phase
    for (int blk = 0; blk < 40; blk++) begin
      write_cfg(8'($urandom));
      for (int i = 0; i < 150; i++)
        step(($urandom % 24) == 0, ($urandom % 5) != 0, 16'($urandom),
             ($urandom % 40) == 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule